// File: doc/BRIEF.md
# Shift-Sequenced Synchronous FIFO with Compare-Only Flags

This block is a single-clock first-in first-out buffer of 16 words. Its write and read addresses are not binary counters. Each address is a 4-bit shift register with XOR feedback, extended so that it also passes through the all-zero code. The address sequence therefore visits all 16 storage slots. One step forward is a left shift with a new bit entering at the bottom. One step back is a right shift with a new bit entering at the top.

The empty, full and half-full flags are registered. They are updated only by equality tests among the forward, present and backward addresses of the pointers. No subtractor and no occupancy counter exist. A third pointer runs eight steps ahead of the read address and moves with it, so the half-full flag can also be decided by one equality test.

A producer drives `push` with `wr_data`, and a consumer drives `pop`. The consumer finds the popped word on `rd_data` one clock later.

Top module: `shift_seq_fifo`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `empty` is 1, `full` is 0, `half_full` is 0 and `rd_data` is 0.
- R2: Each address steps through a 16-state cycle. The next state is the current value shifted left by one. The new bit 0 is bit 3 XOR bit 2, inverted when bits 2..0 are all zero. As a result, exactly 16 words can be held.
- R3: Words come out of `rd_data` in the order in which they were accepted.
- R4: `empty` goes to 1 after a pop that leaves no words. It goes to 0 after any accepted push.
- R5: `full` goes to 1 after a push that makes 16 words stored. It goes to 0 after any accepted pop that comes without a push.
- R6: `half_full` is 1 exactly when 8 or more words are stored, as seen one clock after the push or pop that changed the count.
- R7: A push while `full` is 1 is ignored: the word is not stored and no later pop returns it.
- R8: A pop while `empty` is 1 is ignored: `rd_data` and all flags keep their values.
- R9: When a push and a pop are both accepted in one cycle, the count and all three flags are unchanged. When `empty` is 1 and both are asserted, only the push takes effect. When `full` is 1 and both are asserted, only the pop takes effect.
- R10: `rd_data` is registered. It changes only on the clock edge that takes an accepted pop, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| wr_data | input | 8 | Word written on an accepted push |
| pop | input | 1 | Read request |
| rd_data | output | 8 | Word from the last accepted pop |
| empty | output | 1 | No word stored |
| full | output | 1 | 16 words stored |
| half_full | output | 1 | At least 8 words stored |

## Verification
The assertions assume that `push` and `pop` are free of X after reset. They also assume that the flags alone decide whether a request is accepted. They place no limit on the order of requests, so a push into a full buffer and a pop from an empty one are legal inputs. The stimulus drives these cases on purpose, both alone and together with the opposite request. It then runs a long stretch of independent random push and pop patterns that crosses the 8-word and 16-word limits many times.

// File: rtl/shift_seq_fifo_pkg.sv
package shift_seq_fifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

  function automatic fifo_op_e op_of(input logic do_push, input logic do_pop);
    return fifo_op_e'({do_push, do_pop});
  endfunction
endpackage

// File: rtl/seq_addr_reg.sv
module seq_addr_reg #(
  parameter int          AW          = 4,
  parameter logic [AW-1:0] TAPS      = 4'b1100,
  parameter int          START_STEPS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] prv
);
  function automatic logic [AW-1:0] f_fwd(input logic [AW-1:0] s);
    logic fb;
    fb = (^(s & TAPS)) ^ (s[AW-2:0] == '0);
    return {s[AW-2:0], fb};
  endfunction

  function automatic logic [AW-1:0] f_back(input logic [AW-1:0] s);
    logic top;
    top = s[0] ^ (^(s[AW-1:1] & TAPS[AW-2:0])) ^ (s[AW-1:1] == '0);
    return {top, s[AW-1:1]};
  endfunction

  function automatic logic [AW-1:0] f_walk(input int n);
    logic [AW-1:0] s;
    s = '0;
    for (int i = 0; i < n; i++) s = f_fwd(s);
    return s;
  endfunction

  localparam logic [AW-1:0] SEED = f_walk(START_STEPS);

  always_ff @(posedge clk) begin
    if (rst)       cur <= SEED;
    else if (step) cur <= nxt;
  end

  always_comb nxt = f_fwd(cur);
  always_comb prv = f_back(cur);

  // R2: forward and backward neighbours agree across a step
  assert_step_back_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> prv == $past(cur));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cur));
endmodule

// File: rtl/slot_store.sv
module slot_store #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] slots [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(e)) slot_q <= wdata;
    end
    assign slots[e] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= slots[raddr];
  end

  // R10: output register moves only on an accepted pop
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/cmp_flag_ctl.sv
module cmp_flag_ctl
  import shift_seq_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wr_cur,
  input  logic [AW-1:0] wr_nxt,
  input  logic [AW-1:0] wr_prv,
  input  logic [AW-1:0] rd_cur,
  input  logic [AW-1:0] rdh_cur,
  output logic          empty,
  output logic          full,
  output logic          half,
  output logic          push_ok,
  output logic          pop_ok
);
  fifo_op_e op;
  logic     hits_full, hits_empty, hits_half_up, hits_half_dn;

  always_comb begin
    push_ok      = push && !full;
    pop_ok       = pop && !empty;
    op           = op_of(push_ok, pop_ok);
    hits_full    = (wr_nxt == rd_cur);
    hits_empty   = (wr_prv == rd_cur);
    hits_half_up = (wr_nxt == rdh_cur);
    hits_half_dn = (wr_cur == rdh_cur);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      full  <= 1'b0;
      half  <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          empty <= 1'b0;
          if (hits_full)    full <= 1'b1;
          if (hits_half_up) half <= 1'b1;
        end
        OP_POP: begin
          full <= 1'b0;
          if (hits_empty)   empty <= 1'b1;
          if (hits_half_dn) half  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  assert_full_half_R6: assert property (@(posedge clk) disable iff (rst)
    full |-> half);
  assert_empty_not_half_R6: assert property (@(posedge clk) disable iff (rst)
    empty |-> !half);
  assert_push_clears_empty_R4: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> !empty);
  assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && !push_ok) |=> !full);
  assert_both_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> ($stable(empty) && $stable(full) && $stable(half)));
endmodule

// File: rtl/shift_seq_fifo.sv
module shift_seq_fifo #(
  parameter int             AW   = 4,
  parameter int             DW   = 8,
  parameter logic [AW-1:0]  TAPS = 4'b1100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          half_full
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_cur, wr_nxt, wr_prv;
  logic [AW-1:0] rd_cur, rd_nxt, rd_prv;
  logic [AW-1:0] rdh_cur, rdh_nxt, rdh_prv;

  seq_addr_reg #(.AW(AW), .TAPS(TAPS), .START_STEPS(0)) u_wr (
    .clk(clk), .rst(rst), .step(push_ok),
    .cur(wr_cur), .nxt(wr_nxt), .prv(wr_prv));

  seq_addr_reg #(.AW(AW), .TAPS(TAPS), .START_STEPS(0)) u_rd (
    .clk(clk), .rst(rst), .step(pop_ok),
    .cur(rd_cur), .nxt(rd_nxt), .prv(rd_prv));

  seq_addr_reg #(.AW(AW), .TAPS(TAPS), .START_STEPS(HALF)) u_rdh (
    .clk(clk), .rst(rst), .step(pop_ok),
    .cur(rdh_cur), .nxt(rdh_nxt), .prv(rdh_prv));

  cmp_flag_ctl #(.AW(AW)) u_flags (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_cur(wr_cur), .wr_nxt(wr_nxt), .wr_prv(wr_prv),
    .rd_cur(rd_cur), .rdh_cur(rdh_cur),
    .empty(empty), .full(full), .half(half_full),
    .push_ok(push_ok), .pop_ok(pop_ok));

  slot_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .we(push_ok), .waddr(wr_cur), .wdata(wr_data),
    .re(pop_ok), .raddr(rd_cur), .rdata(rd_data));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(wr_cur));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> ($stable(rd_data) && $stable(rd_cur) && empty));
  assert_rd_step_R2: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (rd_cur == $past(rd_nxt) && rd_prv == $past(rd_cur)));
  assert_half_track_R6: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (rdh_cur == $past(rdh_nxt) && rdh_prv == $past(rdh_cur)));
endmodule

// File: tb/shift_seq_fifo_tb_top.sv
module shift_seq_fifo_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          empty, full, half_full;

  int            n_checks = 0;
  int            n_fails  = 0;
  int            dcnt     = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd = '0;
  bit            done = 0;

  always #4 clk = ~clk;

  shift_seq_fifo dut_i (
    .clk(clk), .rst(rst), .push(push), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .empty(empty), .full(full), .half_full(half_full));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "empty", int'(empty), int'(q.size() == 0));
    chk(tag, "full", int'(full), int'(q.size() == DEPTH));
    chk(tag, "half_full", int'(half_full), int'(q.size() >= DEPTH / 2));
    chk(tag, "rd_data", int'(rd_data), int'(exp_rd));
  endtask

  task automatic step(input logic pu, input logic po, input string tag);
    logic [DW-1:0] d;
    bit pop_acc, push_acc;
    d = DW'(dcnt * 37 + 11);
    dcnt++;
    push = pu; pop = po; wr_data = d;
    pop_acc  = po && (q.size() > 0);
    push_acc = pu && (q.size() < DEPTH);
    if (pop_acc)  exp_rd = q.pop_front();
    if (push_acc) q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    compare(tag);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare("R1");

    step(1, 0, "R4");
    step(0, 1, "R4");
    step(0, 0, "R10");
    step(0, 0, "R10");

    for (int i = 0; i < 7; i++) step(1, 0, "R6");
    step(1, 0, "R6");
    step(0, 1, "R6");
    step(1, 0, "R6");

    for (int i = 0; i < 7; i++) step(1, 0, "R2");
    chk("R2", "full before 16th", int'(full), 0);
    step(1, 0, "R5");
    chk("R2", "full after 16 pushes", int'(full), 1);

    for (int i = 0; i < 3; i++) step(1, 0, "R7");
    step(1, 1, "R9");
    step(1, 0, "R5");
    step(1, 0, "R7");

    for (int i = 0; i < DEPTH; i++) step(0, 1, "R3");
    step(0, 1, "R8");
    step(0, 1, "R8");
    step(1, 1, "R9");
    step(1, 0, "R9");
    step(1, 1, "R9");

    for (int i = 0; i < 2000; i++) begin
      logic a, b;
      a = 1'($urandom % 2);
      b = 1'($urandom % 2);
      step(a, b, "R9");
    end
    for (int i = 0; i < 20; i++) step(0, 1, "R3");
    step(0, 0, "R10");

    done = 1;
    report();
  end
endmodule